// File: doc/BRIEF.md
# Egress Queue Transmit Scheduler

This block sits at the egress side of one switch port and decides which of its NQ transmit queues (NQ is 2, 4 or 8, fixed at build time) may send the next packet. Every queue carries a pending flag from the buffer logic. When the port is idle and at least one queue is pending, the scheduler issues a one-hot grant. The transmit path then moves one whole packet from that queue and pulses `eop` on the packet's last cycle. The grant works as a transfer permission: it cannot be withdrawn, so the transmit path applies back-pressure only by delaying `eop`. The grant holds its value until `eop` arrives. After a release the port is idle for one cycle, and the next grant comes one cycle after that.

Each queue runs in one of two modes. In strict-priority mode the queue is served ahead of every round-robin queue. In weighted round-robin mode the queue takes turns with the other round-robin queues, and its weight sets how many whole packets it may send in one turn. Software reaches the mode and the weight of a queue through an index register. Each queue also has an 8-bit egress rate limit. Writes to the limits are staged and take effect together. While any active limit is nonzero, ordered scheduling is suspended, the port falls back to plain rotation, and a status pin reports the condition.

Top module: `egress_sched`

## Requirements
- R1: `grant` is zero or one-hot, and it is issued one cycle after the port is idle with at least one queue pending. It goes only to a queue that was pending when it was chosen. With no queue pending, `grant` stays zero.
- R2: Once issued, `grant` keeps its value until a cycle with `eop` high. It is zero in the cycle after that, even if queues are still pending.
- R3: Register map on the `cfg_*` write port. Address 0 is the queue index (low bits of data). Address 1 is the mode of the indexed queue, where bit 0 = 1 selects strict priority and bit 0 = 0 selects round robin. Address 2 is the weight of the indexed queue. Addresses 8 to 8+NQ-1 are the rate limits of queues 0 to NQ-1.
- R4: After reset, every queue is round robin with weight 1, all limits are 0, `grant` is 0 and `limit_active` is 0. The first round-robin grant goes to queue 0.
- R5: A pending strict queue always wins over round-robin queues. Among pending strict queues, the highest-numbered one wins.
- R6: In round robin, the queue in service keeps its turn for `weight` packets. The turn then passes to the next pending round-robin queue in ascending cyclic order. A weight of 0 acts as 1.
- R7: If the queue in service is not pending when a choice is made, the turn moves on at once. The count of the new queue restarts at 1.
- R8: A write to the limit of any queue other than the highest-numbered one is only staged and changes nothing. A write to the highest-numbered queue's limit makes all staged limits and the written value active together.
- R9: While any active limit is nonzero, `limit_active` is 1. During that time grants rotate over all pending queues in ascending cyclic order, starting after the last granted queue, and modes and weights are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| q_pend | input | NQ | Per-queue packet pending flags |
| eop | input | 1 | End of the granted packet |
| grant | output | NQ | One-hot transmit grant |
| limit_active | output | 1 | An active rate limit is nonzero |

## Verification
The hardest case to reach is a round-robin turn that ends because the serviced queue empties partway through its weight. The stimulus has to drop exactly that queue's pending flag at a choice point while another round-robin queue waits. The vector table first builds up a partial count on one queue and then removes that queue's flag, so both the early rotation and the count restart show up in the grants. The staged limit writes are handled in the same way. A nonzero limit goes to a lower queue, `limit_active` and the strict ordering are checked as unchanged, and only then is the last queue's register written.

// File: rtl/egsched_pkg.sv
package egsched_pkg;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = 8;
  localparam logic [CFG_AW-1:0] A_IDX  = 4'd0;
  localparam logic [CFG_AW-1:0] A_MODE = 4'd1;
  localparam logic [CFG_AW-1:0] A_WGT  = 4'd2;
  localparam int A_RL = 8;
  typedef enum logic { M_WRR = 1'b0, M_STRICT = 1'b1 } qmode_e;
endpackage

// File: rtl/egsched_cfg.sv
module egsched_cfg
  import egsched_pkg::*;
#(
  parameter int NQ = 4,
  parameter int WW = 8,
  localparam int QW = $clog2(NQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [CFG_DW-1:0]        cfg_wdata,
  output logic [NQ-1:0]            strict_mask,
  output logic [NQ-1:0][WW-1:0]    wgt,
  output logic                     limit_on
);
  logic [QW-1:0]              idx_q;
  qmode_e                     mode_q   [NQ];
  logic [NQ-1:0][WW-1:0]      wgt_q;
  logic [NQ-1:0][CFG_DW-1:0]  rl_stage_q;
  logic [NQ-1:0][CFG_DW-1:0]  rl_act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= '0;
      rl_stage_q <= '0;
      rl_act_q   <= '0;
      for (int q = 0; q < NQ; q++) begin
        mode_q[q] <= M_WRR;
        wgt_q[q]  <= WW'(1);
      end
    end else if (cfg_we) begin
      if (cfg_addr == A_IDX)  idx_q         <= cfg_wdata[QW-1:0];
      if (cfg_addr == A_MODE) mode_q[idx_q] <= qmode_e'(cfg_wdata[0]);
      if (cfg_addr == A_WGT)  wgt_q[idx_q]  <= cfg_wdata[WW-1:0];
      for (int q = 0; q < NQ; q++) begin
        if (int'(cfg_addr) == A_RL + q) begin
          rl_stage_q[q] <= cfg_wdata;
          if (q == NQ - 1) begin
            for (int j = 0; j < NQ - 1; j++) rl_act_q[j] <= rl_stage_q[j];
            rl_act_q[NQ-1] <= cfg_wdata;
          end
        end
      end
    end
  end

  always_comb begin
    limit_on = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      strict_mask[q] = (mode_q[q] == M_STRICT);
      if (rl_act_q[q] != '0) limit_on = 1'b1;
    end
  end
  assign wgt = wgt_q;

  // R8: staging writes below the last queue leave the active limits alone
  a_r8_staged_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_addr) >= A_RL && int'(cfg_addr) < A_RL + NQ - 1)
      |=> $stable(limit_on));

  // R3: modes move only on a write to the mode address
  a_r3_mode_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == A_MODE) |=> $stable(strict_mask));
endmodule

// File: rtl/egsched_rrfind.sv
module egsched_rrfind #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         found,
  output logic [W-1:0] idx
);
  logic [W-1:0] cand;
  always_comb begin
    found = 1'b0;
    idx   = ptr;
    cand  = ptr;
    // Scan from farthest to nearest so the nearest request after ptr wins;
    // ptr itself (k = N) is the last resort.
    for (int k = N; k >= 1; k--) begin
      cand = ptr + W'(k);
      if (req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/egress_sched.sv
module egress_sched
  import egsched_pkg::*;
#(
  parameter int NQ = 4,
  parameter int WW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [NQ-1:0]     q_pend,
  input  logic              eop,
  output logic [NQ-1:0]     grant,
  output logic              limit_active
);
  localparam int QW = $clog2(NQ);

  logic [NQ-1:0]          strict_mask;
  logic [NQ-1:0][WW-1:0]  wgt;
  logic                   limit_on;

  egsched_cfg #(.NQ(NQ), .WW(WW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .strict_mask(strict_mask), .wgt(wgt),
    .limit_on(limit_on)
  );

  logic [NQ-1:0] grant_q;
  logic [QW-1:0] last_q, wptr_q;
  logic [WW-1:0] wsent_q;
  logic          busy;
  assign busy = |grant_q;

  logic [NQ-1:0] strict_req, wrr_req;
  assign strict_req = q_pend & strict_mask;
  assign wrr_req    = q_pend & ~strict_mask;

  logic          rr_found, w_found;
  logic [QW-1:0] rr_idx, w_idx;

  egsched_rrfind #(.N(NQ)) u_rr_all (
    .req(q_pend), .ptr(last_q), .found(rr_found), .idx(rr_idx));
  egsched_rrfind #(.N(NQ)) u_rr_wrr (
    .req(wrr_req), .ptr(wptr_q), .found(w_found), .idx(w_idx));

  logic [WW-1:0] w_eff;
  logic          stay_ok;
  assign w_eff   = (wgt[wptr_q] == '0) ? WW'(1) : wgt[wptr_q];
  assign stay_ok = wrr_req[wptr_q] && (wsent_q < w_eff);

  logic          pick_v, pick_wrr, pick_rot;
  logic [QW-1:0] pick_idx;
  always_comb begin
    pick_v   = 1'b0;
    pick_wrr = 1'b0;
    pick_rot = 1'b0;
    pick_idx = '0;
    if (limit_on) begin
      pick_v   = rr_found;
      pick_idx = rr_idx;
    end else if (|strict_req) begin
      pick_v = 1'b1;
      for (int q = 0; q < NQ; q++)
        if (strict_req[q]) pick_idx = QW'(q);
    end else if (stay_ok) begin
      pick_v   = 1'b1;
      pick_wrr = 1'b1;
      pick_idx = wptr_q;
    end else if (w_found) begin
      pick_v   = 1'b1;
      pick_wrr = 1'b1;
      pick_rot = 1'b1;
      pick_idx = w_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= QW'(NQ - 1);
      wptr_q  <= QW'(NQ - 1);
      wsent_q <= '1;
    end else if (!busy) begin
      if (pick_v) begin
        grant_q  <= '0;
        grant_q[pick_idx] <= 1'b1;
        last_q   <= pick_idx;
        if (pick_wrr) begin
          if (pick_rot) begin
            wptr_q  <= pick_idx;
            wsent_q <= WW'(1);
          end else begin
            wsent_q <= wsent_q + WW'(1);
          end
        end
      end
    end else if (eop) begin
      grant_q <= '0;
    end
  end

  assign grant        = grant_q;
  assign limit_active = limit_on;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r1_to_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && q_pend != '0) |=> ((grant & $past(q_pend)) != '0));

  a_r1_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && q_pend == '0) |=> (grant == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !eop) |=> (grant == $past(grant)));

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && eop) |=> (grant == '0));

  a_r5_strict_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && !limit_active && (q_pend & strict_mask) != '0)
      |=> ((grant & $past(q_pend & strict_mask)) != '0));
endmodule

// File: tb/sim_egress_sched.sv
`timescale 1ns/1ps
module sim_egress_sched;
  localparam int NQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [NQ-1:0] q_pend = '0;
  logic eop = 1'b0;
  logic [NQ-1:0] grant;
  logic limit_active;

  always #10 clk = ~clk;

  egress_sched #(.NQ(NQ)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .q_pend(q_pend), .eop(eop), .grant(grant),
    .limit_active(limit_active)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one packet: grant appears one cycle later, holds, releases on eop
  task automatic serve(logic [NQ-1:0] p, int q, string req);
    @(negedge clk);
    q_pend = p;
    @(negedge clk);
    chk(req, int'(grant), 1 << q);
    @(negedge clk);
    chk("R2 hold", int'(grant), 1 << q);
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
    q_pend = '0;
    chk("R2 release", int'(grant), 0);
  endtask

  // op[15:14]: 0 write(addr,data) 1 serve(pend,queue) 2 status(expected)
  localparam int NV = 47;
  localparam logic [15:0] VEC [NV] = '{
    {2'd1,6'hF,8'd0}, {2'd1,6'hF,8'd1}, {2'd1,6'hF,8'd2}, {2'd1,6'hF,8'd3},
    {2'd1,6'hF,8'd0}, {2'd1,6'h5,8'd2}, {2'd1,6'h5,8'd0}, {2'd1,6'h5,8'd2},
    {2'd0,6'd0,8'd1}, {2'd0,6'd2,8'd3},
    {2'd1,6'hF,8'd3}, {2'd1,6'hF,8'd0}, {2'd1,6'hF,8'd1}, {2'd1,6'hF,8'd1},
    {2'd1,6'hF,8'd1}, {2'd1,6'hF,8'd2},
    {2'd0,6'd0,8'd3}, {2'd0,6'd2,8'd0},
    {2'd1,6'hF,8'd3}, {2'd1,6'hF,8'd0},
    {2'd0,6'd0,8'd0}, {2'd0,6'd2,8'd4},
    {2'd1,6'h3,8'd0}, {2'd1,6'h2,8'd1}, {2'd1,6'h3,8'd1}, {2'd1,6'h1,8'd0},
    {2'd1,6'h3,8'd0},
    {2'd0,6'd0,8'd2}, {2'd0,6'd1,8'd1},
    {2'd1,6'hF,8'd2}, {2'd1,6'hF,8'd2},
    {2'd0,6'd0,8'd3}, {2'd0,6'd1,8'd1},
    {2'd1,6'hF,8'd3}, {2'd1,6'h7,8'd2}, {2'd1,6'h3,8'd0},
    {2'd2,6'd0,8'd0},
    {2'd0,6'd8,8'd5}, {2'd2,6'd0,8'd0}, {2'd1,6'hF,8'd3},
    {2'd0,6'd11,8'd0}, {2'd2,6'd0,8'd1},
    {2'd1,6'hF,8'd0}, {2'd1,6'hF,8'd1}, {2'd1,6'hF,8'd2}, {2'd1,6'hF,8'd3},
    {2'd1,6'h5,8'd0}
  };

  function automatic string tag_of(int i);
    if (i < 8)  return "R6 default rotation (R4)";
    if (i < 22) return "R6 weight/R3 indexed";
    if (i < 27) return "R7 empty queue reload";
    if (i < 37) return "R5 strict priority";
    if (i < 42) return "R8 staged limit";
    return "R9 plain rotation";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset grant", int'(grant), 0);
    chk("R4 reset limit", int'(limit_active), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle no grant", int'(grant), 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][15:14])
        2'd0: wr(VEC[i][11:8], VEC[i][7:0]);
        2'd1: serve(VEC[i][11:8], int'(VEC[i][7:0]), tag_of(i));
        default: begin
          @(negedge clk);
          chk({tag_of(i), " status"}, int'(limit_active), int'(VEC[i][0]));
        end
      endcase
    end

    // R8: clearing a low limit alone keeps the old active set
    wr(4'd8, 8'd0);
    @(negedge clk);
    chk("R8 still active", int'(limit_active), 1);
    serve(4'hF, 1, "R9 rotation continues");
    wr(4'd11, 8'd0);
    @(negedge clk);
    chk("R8 cleared on last write", int'(limit_active), 0);
    serve(4'hF, 3, "R5 strict after clear");

    // R2: grant held while pending drops and eop stays low
    @(negedge clk);
    q_pend = 4'b0100;
    @(negedge clk);
    chk("R5 single strict", int'(grant), 4);
    q_pend = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 hold without pending", int'(grant), 4);
    end
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
    chk("R2 release", int'(grant), 0);

    // R4: reset restores round robin with weight 1 (strict modes cleared)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R4 grant after reset", int'(grant), 0);
    serve(4'hF, 0, "R4 modes back to round robin");
    serve(4'hF, 1, "R4 weight back to 1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule